// File: doc/BRIEF.md
# Start/Stop Framed Word Serializer

This block turns a stream of 10-bit parallel words into a single serial line. Each word is wrapped in a 12-slot frame. The first slot is always high, the last slot is always low, and the data bits sit between them. Every frame therefore carries a guaranteed falling-to-rising edge that a receiver can recover its clock from. The block runs on one clock. A bit-rate enable advances the line by one slot, and a new word is taken once every twelve enables, which is the reference (word) rate. The payload rate is ten twelfths of the line rate.

After reset the line driver is disabled and the output-enable stays low while a lock timer counts whole frames, as a stand-in for a clock multiplier that is settling. When the timer expires, ready and output-enable rise together. The first frame put on the line carries all-zero data, so that a receiver can reacquire the frame. A resync request forces zero data at any later time. The forcing lasts for as long as the request is seen at word capture, plus one further frame after it is released.

Top module: `framed_serializer`

## Requirements
- R1: A frame occupies 12 slots sent in order. Slot 0 is the start bit (1). Slots 1 to 10 carry data bits 0 to 9, least significant first. Slot 11 is the stop bit (0).
- R2: `word_in` is sampled only at the clock edge where `bit_en` is high while the line is in slot 11, and that word becomes the next frame's data. At every other edge `word_in` has no effect on `ser_out`.
- R3: The line advances by exactly one slot per clock edge with `bit_en` high. With `bit_en` low, `ser_out`, `ser_oe` and `ready` hold their values.
- R4: After reset, `ser_oe` and `ready` stay low until LOCK_FRAMES (2049) whole frames have elapsed, which is 2049*12 = 24588 bit enables. Both rise at the edge that ends the last of those frames.
- R5: Once high, `ready` and `ser_oe` stay high and equal until reset.
- R6: The first frame driven after `ser_oe` rises carries all-zero data, with start and stop bits intact.
- R7: If `resync_req` is high when a word is captured, that frame's data is all zero. The frame captured next is also all zero, whatever `resync_req` is then. Start and stop bits are still inserted.
- R8: While `ser_oe` is low, `ser_out` is 0.
- R9: `rst_n` low immediately clears `ser_oe`, `ready` and `ser_out`. Its release takes effect two clock edges later, and the block restarts the lock interval from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at or above the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_en | input | 1 | Bit-rate enable; one line slot per high cycle |
| word_in | input | 10 | Parallel payload word |
| resync_req | input | 1 | Request all-zero data frames for receiver relock |
| ser_out | output | 1 | Serial line bit |
| ser_oe | output | 1 | Line driver enable; low means tri-stated |
| ready | output | 1 | Lock interval finished, block transmitting |

## Verification
The line is checked slot by slot against a bench model under random word values and an enable that has irregular gaps. The gaps separate slot advance from plain clock edges. Directed segments send all-ones words, which make the stop slot the only low bit in a frame, and walking-one words, which expose any bit-order or slot-offset error. Bursts of resync requests of random length check that zero data lasts exactly one frame beyond the last request seen. The lock length is counted independently as the number of enables until ready rises, and a mid-run reset checks that the outputs drop immediately and that the lock interval restarts in full.

// File: rtl/ser_frame_pkg.sv
package ser_frame_pkg;
  typedef enum logic {
    PH_LOCKING = 1'b0,
    PH_LIVE    = 1'b1
  } ser_phase_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ser_reset_sync.sv
module ser_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_one
      assign pipe_d = 1'b1;
    end else begin : g_many
      assign pipe_d = {pipe_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_core_n = pipe_q[STAGES-1];
endmodule

// File: rtl/ser_slot_counter.sv
module ser_slot_counter #(
  parameter int unsigned SLOTS = 12,
  localparam int unsigned CW   = ser_frame_pkg::cnt_width(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  output logic [CW-1:0] slot,
  output logic          frame_end
);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  logic [CW-1:0] slot_q;
  logic [CW-1:0] slot_d;

  assign frame_end = bit_en && (slot_q == LAST);

  always_comb begin
    slot_d = slot_q;
    if (bit_en) begin
      if (slot_q == LAST) slot_d = '0;
      else                slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot = slot_q;
endmodule

// File: rtl/ser_lock_timer.sv
module ser_lock_timer #(
  parameter int unsigned LOCK_FRAMES = 2049,
  localparam int unsigned LW         = ser_frame_pkg::cnt_width(LOCK_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  output logic live
);
  import ser_frame_pkg::*;

  localparam logic [LW-1:0] LAST = LW'(LOCK_FRAMES - 1);

  logic [LW-1:0] cnt_q;
  logic [LW-1:0] cnt_d;
  ser_phase_e    ph_q;
  ser_phase_e    ph_d;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (ph_q == PH_LOCKING && frame_end) begin
      if (cnt_q == LAST) ph_d = PH_LIVE;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_LOCKING;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign live = (ph_q == PH_LIVE);
endmodule

// File: rtl/ser_frame_shifter.sv
module ser_frame_shifter #(
  parameter int unsigned DATA_W = 10,
  localparam int unsigned SLOTS = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              frame_end,
  input  logic              force_zero,
  input  logic [DATA_W-1:0] word_in,
  output logic              line_bit
);
  logic [SLOTS-1:0]  sh_q;
  logic [SLOTS-1:0]  sh_d;
  logic [DATA_W-1:0] payload;

  assign payload = force_zero ? '0 : word_in;

  always_comb begin
    sh_d = sh_q;
    if (frame_end)   sh_d = {1'b0, payload, 1'b1};
    else if (bit_en) sh_d = {1'b0, sh_q[SLOTS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign line_bit = sh_q[0];
endmodule

// File: rtl/framed_serializer.sv
module framed_serializer #(
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned LOCK_FRAMES = 2049,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] word_in,
  input  logic              resync_req,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              ready
);
  localparam int unsigned SLOTS = DATA_W + 2;
  localparam int unsigned CW    = ser_frame_pkg::cnt_width(SLOTS);

  logic          rst_core_n;
  logic [CW-1:0] slot_idx;
  logic          frame_end;
  logic          live;
  logic          line_bit;
  logic          hold_q;
  logic          hold_d;
  logic          force_zero;

  ser_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  ser_slot_counter #(.SLOTS(SLOTS)) u_slot (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bit_en    (bit_en),
    .slot      (slot_idx),
    .frame_end (frame_end)
  );

  ser_lock_timer #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .frame_end (frame_end),
    .live      (live)
  );

  // zero data while locking, on request, and for one frame after a request
  assign force_zero = !live || resync_req || hold_q;

  always_comb begin
    hold_d = hold_q;
    if (frame_end) hold_d = resync_req;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) hold_q <= 1'b0;
    else             hold_q <= hold_d;
  end

  ser_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bit_en     (bit_en),
    .frame_end  (frame_end),
    .force_zero (force_zero),
    .word_in    (word_in),
    .line_bit   (line_bit)
  );

  assign ser_oe  = live;
  assign ready   = live;
  assign ser_out = live & line_bit;
endmodule

// File: rtl/framed_serializer_chk.sv
module framed_serializer_chk #(
  parameter int unsigned SLOTS       = 12,
  parameter int unsigned LOCK_FRAMES = 2049,
  parameter int unsigned CW          = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic [CW-1:0] slot,
  input logic          ser_out,
  input logic          ser_oe,
  input logic          ready
);
  logic [31:0] frames_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                         frames_seen <= '0;
    else if (bit_en && slot == CW'(SLOTS - 1) && !ready) frames_seen <= frames_seen + 1;
  end

  // R1
  start_slot_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && slot == '0) |-> ser_out);

  // R1
  stop_slot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && slot == CW'(SLOTS - 1)) |-> !ser_out);

  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= CW'(SLOTS - 1));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(slot) && $stable(ser_out) && $stable(ser_oe)));

  // R4
  ready_on_frame_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(bit_en) && $past(slot) == CW'(SLOTS - 1)));

  // R4
  lock_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (frames_seen == LOCK_FRAMES));

  // R5
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R5
  oe_matches_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_oe == ready);

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |-> !ser_out);
endmodule

bind framed_serializer framed_serializer_chk #(
  .SLOTS       (SLOTS),
  .LOCK_FRAMES (LOCK_FRAMES),
  .CW          (CW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .bit_en  (bit_en),
  .slot    (slot_idx),
  .ser_out (ser_out),
  .ser_oe  (ser_oe),
  .ready   (ready)
);

// File: tb/test_framed_serializer.sv
module test_framed_serializer;
  localparam int unsigned DATA_W = 10;
  localparam int unsigned LOCK   = 2049;
  localparam int unsigned SLOTS  = DATA_W + 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bit_en;
  logic [DATA_W-1:0] word_in;
  logic              resync_req;
  logic              ser_out;
  logic              ser_oe;
  logic              ready;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model state, from the requirements
  int             m_slot;
  int             m_frames;
  bit             m_live;
  bit             m_hold;
  logic [SLOTS-1:0] m_sh;
  bit             m_cur_zero;
  bit             m_first;
  bit             m_last_en;
  int             en_count;
  bit             ready_seen;

  always #2 clk = ~clk;

  framed_serializer #(.DATA_W(DATA_W), .LOCK_FRAMES(LOCK)) i_framed_serializer (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .word_in    (word_in),
    .resync_req (resync_req),
    .ser_out    (ser_out),
    .ser_oe     (ser_oe),
    .ready      (ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [SLOTS-1:0] frame_of(input logic [DATA_W-1:0] w, input bit zero);
    return {1'b0, (zero ? {DATA_W{1'b0}} : w), 1'b1};
  endfunction

  function automatic string line_tag();
    if (!m_live)            return "R8 line quiet while off";
    if (!m_last_en)         return "R3 line held without enable";
    if (m_slot == 0)        return "R1 start slot";
    if (m_slot == SLOTS-1)  return "R1 stop slot";
    if (m_first)            return "R6 first frame zero data";
    if (m_cur_zero)         return "R7 resync zero data";
    return "R2 data slot";
  endfunction

  task automatic model_reset();
    m_slot = 0; m_frames = 0; m_live = 0; m_hold = 0; m_sh = '0;
    m_cur_zero = 0; m_first = 0; m_last_en = 1; en_count = 0; ready_seen = 0;
  endtask

  task automatic check_outputs();
    if (!ready_seen && ready) begin
      chk(en_count == LOCK*SLOTS, "R4 enables before ready", en_count, LOCK*SLOTS);
      ready_seen = 1;
    end
    chk(ser_oe == m_live, "R4 ser_oe", ser_oe, m_live);
    chk(ready == m_live, "R5 ready", ready, m_live);
    chk(ser_out == (m_live & m_sh[0]), line_tag(), ser_out, m_live & m_sh[0]);
  endtask

  // one clock: check at negedge, drive, then advance model at posedge
  task automatic step(input bit en, input logic [DATA_W-1:0] w, input bit rs);
    @(negedge clk);
    check_outputs();
    bit_en = en; word_in = w; resync_req = rs;
    @(posedge clk);
    m_last_en = en;
    if (en) begin
      en_count++;
      if (m_slot == SLOTS-1) begin
        bit zero;
        zero = !m_live || rs || m_hold;
        m_first = !m_live && (m_frames == LOCK-1);
        m_cur_zero = zero;
        m_sh = frame_of(w, zero);
        m_hold = rs;
        m_slot = 0;
        if (!m_live) begin
          m_frames++;
          if (m_frames == LOCK) m_live = 1;
        end
      end else begin
        m_slot++;
        m_sh = m_sh >> 1;
        if (m_slot == 1) m_first = m_first;
      end
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_en = 1'b0;
    #1;
    // R9 outputs drop at once
    chk(ser_oe == 1'b0, "R9 ser_oe in reset", ser_oe, 0);
    chk(ready == 1'b0, "R9 ready in reset", ready, 0);
    chk(ser_out == 1'b0, "R9 ser_out in reset", ser_out, 0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0);
    en_count = 0;
  endtask

  task automatic run_lock();
    while (!m_live) step(($urandom % 8) != 0, DATA_W'($urandom), ($urandom % 4) == 0);
    // R6 the first live frame: walk it out
    for (int i = 0; i < SLOTS * 2; i++) step(1'b1, '1, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0a17));
    rst_n = 1'b0; bit_en = 1'b0; word_in = '0; resync_req = 1'b0;
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    // R9 reset state
    chk(ser_oe == 1'b0, "R9 reset ser_oe", ser_oe, 0);
    chk(ready == 1'b0, "R9 reset ready", ready, 0);
    chk(ser_out == 1'b0, "R8 reset ser_out", ser_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0);
    en_count = 0;

    run_lock();

    // R2 random words, random enable gaps
    for (int i = 0; i < 1500; i++) step(($urandom % 5) != 0, DATA_W'($urandom), 1'b0);
    // R1 all-ones words: stop slot is the only low bit
    for (int i = 0; i < 400; i++) step(1'b1, '1, 1'b0);
    // R1 walking one for bit order
    for (int k = 0; k < DATA_W; k++)
      for (int i = 0; i < SLOTS; i++) step(1'b1, DATA_W'(1) << k, 1'b0);
    // R7 resync bursts of random length
    begin
      bit rs = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        if (($urandom % 40) == 0) rs = !rs;
        step(($urandom % 6) != 0, DATA_W'($urandom) | 10'h001, rs);
      end
    end
    // R3 long idle stretch mid-frame
    for (int i = 0; i < 5; i++) step(1'b1, '1, 1'b0);
    for (int i = 0; i < 30; i++) step(1'b0, DATA_W'($urandom), 1'b1);
    for (int i = 0; i < 60; i++) step(1'b1, '1, 1'b0);

    // R9 reset mid-run restarts the full lock interval
    apply_reset();
    run_lock();
    for (int i = 0; i < 300; i++) step(($urandom % 3) != 0, DATA_W'($urandom), ($urandom % 10) == 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule